// File: doc/BRIEF.md
# Debug Hit Qualifier

This block sits between the raw address comparators of a processor's debug unit and its exception logic. A comparator raises a one-cycle strobe when an instruction address matches the breakpoint register, or when a data access matches the watchpoint register. The qualifier then decides whether that strobe becomes an exception. A breakpoint is gated by a two-bit privilege selector checked against the current problem and hypervisor state bits. A watchpoint is gated by a set of privilege enables and by a rule that matches the data translation mode.

A qualified hit becomes a registered exception request, presented on a valid/ready output. The request carries an exception kind, a fault address and a 64-bit syndrome word with a fixed bit pattern for each kind. Strobes are accepted only while `hit_rdy` is high. `hit_rdy` is low while a request is held or a second request is queued. Strobes that arrive while `hit_rdy` is low are ignored, so the core must not issue debug matches then. On the output side, a request stays on the port with every field stable until the cycle in which `exc_valid` and `exc_ready` are both high.

Top module: `dbg_hit_qualifier`

## Requirements
- R1: After reset, `exc_valid` is 0 and `hit_rdy` is 1.
- R2: A breakpoint strobe fires under these conditions, and only these:
  - selector 1 with `msr_pr`=1;
  - selector 2 with `msr_pr`=0 and `msr_hv`=0;
  - selector 3 with `msr_pr`=0 and `msr_hv`=1.
- R3: Breakpoint selector value 0 never fires, whatever the state.
- R4: `wp_ctl` bit 0 is the problem-state enable, bit 1 the supervisor enable and bit 2 the hypervisor enable. The watchpoint is suppressed in the first of these cases that applies, checked in this order:
  - `msr_pr`=1 with bit 0 clear;
  - `msr_hv`=1 with bit 2 clear;
  - bit 1 clear.
- R5: `wp_ctl` bit 3 is translation-ignore and bit 4 is the expected translation mode. While bit 3 is 0, a watchpoint fires only if bit 4 equals `msr_dr`. While bit 3 is 1, `msr_dr` is not checked.
- R6: A qualified watchpoint gives a request with these fields:
  - `exc_kind`=1 (data storage);
  - `exc_addr` equal to `wp_addr`;
  - `exc_info`=64'h0000_0000_0040_0000, which is bit 41 in MSB-0 numbering.
- R7: A qualified breakpoint gives a request with these fields:
  - `exc_kind`=2 (trace);
  - `exc_addr`=0;
  - `exc_info`=64'h0000_0000_4010_0000, which is bits 33 and 43 in MSB-0 numbering.
- R8: While `feat_en` is 0, no strobe produces a request.
- R9: When both strobes qualify in the same cycle, the watchpoint request is presented first. The breakpoint request follows in the cycle after the watchpoint request is accepted.
- R10: While `exc_valid`=1 and `exc_ready`=0, the request fields stay stable and `hit_rdy` is 0. Strobes in that time are ignored.
- R11: A qualified strobe accepted with `hit_rdy`=1 raises `exc_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| feat_en | input | 1 | Debug qualification enable |
| msr_pr | input | 1 | Problem (user) state bit |
| msr_hv | input | 1 | Hypervisor state bit |
| msr_dr | input | 1 | Data translation enabled bit |
| bp_hit | input | 1 | Raw instruction breakpoint match strobe |
| bp_priv | input | 2 | Breakpoint privilege selector |
| wp_hit | input | 1 | Raw data watchpoint match strobe |
| wp_addr | input | AW | Address that hit the watchpoint |
| wp_ctl | input | 5 | Watchpoint control: {mode, ignore, hv_en, sv_en, pr_en} |
| hit_rdy | output | 1 | Strobes are accepted this cycle |
| exc_valid | output | 1 | Exception request present |
| exc_ready | input | 1 | Exception logic accepts the request |
| exc_kind | output | 2 | 1 data storage, 2 trace |
| exc_addr | output | AW | Fault address |
| exc_info | output | 64 | Syndrome word |

## Verification
A strobe driven with `hit_rdy` high must show up as `exc_valid` one rising edge later. The bench samples on the falling edge that follows, as a separate timed check. A scoreboard entry is compared when the handshake completes at the falling edge. A deferred breakpoint is due one edge after the watchpoint's handshake, so it is compared at the next falling edge. After each stimulus the bench waits four cycles and then requires the expected queue to be empty. This catches both missing and extra requests, including strobes that should have been ignored.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;
  localparam int INFO_W = 64;
  localparam int CTL_W  = 5;
  // watchpoint control bit positions
  localparam int WC_PR_EN = 0;
  localparam int WC_SV_EN = 1;
  localparam int WC_HV_EN = 2;
  localparam int WC_IGN   = 3;
  localparam int WC_MODE  = 4;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_DSI   = 2'd1,
    KIND_TRACE = 2'd2
  } exc_kind_e;

  typedef enum logic [1:0] {
    SEL_OFF = 2'd0,
    SEL_PROB = 2'd1,
    SEL_SUP = 2'd2,
    SEL_HYP = 2'd3
  } bp_sel_e;

  // syndrome words, MSB-0 bit n maps to LSB-0 bit (63-n)
  localparam logic [INFO_W-1:0] DSI_INFO   = 64'h1 << (63 - 41);
  localparam logic [INFO_W-1:0] TRACE_INFO = (64'h1 << (63 - 33)) | (64'h1 << (63 - 43));
endpackage

// File: rtl/dbgq_bp_qual.sv
module dbgq_bp_qual
  import dbgq_pkg::*;
(
  input  logic       en,
  input  logic       hit,
  input  logic [1:0] sel,
  input  logic       pr,
  input  logic       hv,
  output logic       fire
);
  logic state_ok;

  always_comb begin
    case (bp_sel_e'(sel))
      SEL_PROB: state_ok = pr;
      SEL_SUP:  state_ok = !pr && !hv;
      SEL_HYP:  state_ok = !pr && hv;
      default:  state_ok = 1'b0;
    endcase
  end

  assign fire = en && hit && state_ok;
endmodule

// File: rtl/dbgq_wp_qual.sv
module dbgq_wp_qual
  import dbgq_pkg::*;
(
  input  logic             en,
  input  logic             hit,
  input  logic [CTL_W-1:0] ctl,
  input  logic             pr,
  input  logic             hv,
  input  logic             dr,
  output logic             fire
);
  logic priv_ok;
  logic xlat_ok;

  always_comb begin
    if (pr && !ctl[WC_PR_EN])      priv_ok = 1'b0;
    else if (hv && !ctl[WC_HV_EN]) priv_ok = 1'b0;
    else if (!ctl[WC_SV_EN])       priv_ok = 1'b0;
    else                           priv_ok = 1'b1;
  end

  assign xlat_ok = ctl[WC_IGN] || (ctl[WC_MODE] == dr);
  assign fire    = en && hit && priv_ok && xlat_ok;
endmodule

// File: rtl/dbgq_req_reg.sv
module dbgq_req_reg
  import dbgq_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_fire,
  input  logic              bp_fire,
  input  logic [AW-1:0]     wp_addr,
  output logic              can_take,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [1:0]        out_kind,
  output logic [AW-1:0]     out_addr,
  output logic [INFO_W-1:0] out_info
);
  logic bp_pend;

  assign can_take = !out_valid && !bp_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_kind  <= KIND_NONE;
      out_addr  <= '0;
      out_info  <= '0;
      bp_pend   <= 1'b0;
    end else if (out_valid && out_ready) begin
      if (bp_pend) begin
        out_kind <= KIND_TRACE;
        out_addr <= '0;
        out_info <= TRACE_INFO;
        bp_pend  <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        out_kind  <= KIND_NONE;
        out_info  <= '0;
      end
    end else if (can_take) begin
      if (wp_fire) begin
        out_valid <= 1'b1;
        out_kind  <= KIND_DSI;
        out_addr  <= wp_addr;
        out_info  <= DSI_INFO;
        bp_pend   <= bp_fire;
      end else if (bp_fire) begin
        out_valid <= 1'b1;
        out_kind  <= KIND_TRACE;
        out_addr  <= '0;
        out_info  <= TRACE_INFO;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_addr) && $stable(out_info));

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    can_take && (wp_fire || bp_fire) |=> out_valid);

  p_wp_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    can_take && wp_fire && bp_fire |=> out_valid && out_kind == KIND_DSI);

  p_bp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && bp_pend |=> out_valid && out_kind == KIND_TRACE);

  p_dsi_info_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == KIND_DSI |-> out_info == DSI_INFO);

  p_trace_info_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kind == KIND_TRACE |-> out_info == TRACE_INFO && out_addr == '0);
endmodule

// File: rtl/dbg_hit_qualifier.sv
module dbg_hit_qualifier
  import dbgq_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feat_en,
  input  logic              msr_pr,
  input  logic              msr_hv,
  input  logic              msr_dr,
  input  logic              bp_hit,
  input  logic [1:0]        bp_priv,
  input  logic              wp_hit,
  input  logic [AW-1:0]     wp_addr,
  input  logic [CTL_W-1:0]  wp_ctl,
  output logic              hit_rdy,
  output logic              exc_valid,
  input  logic              exc_ready,
  output logic [1:0]        exc_kind,
  output logic [AW-1:0]     exc_addr,
  output logic [INFO_W-1:0] exc_info
);
  logic bp_fire;
  logic wp_fire;

  dbgq_bp_qual u_bp (
    .en(feat_en), .hit(bp_hit), .sel(bp_priv),
    .pr(msr_pr), .hv(msr_hv), .fire(bp_fire)
  );

  dbgq_wp_qual u_wp (
    .en(feat_en), .hit(wp_hit), .ctl(wp_ctl),
    .pr(msr_pr), .hv(msr_hv), .dr(msr_dr), .fire(wp_fire)
  );

  dbgq_req_reg #(.AW(AW)) u_req (
    .clk(clk), .rst_n(rst_n),
    .wp_fire(wp_fire), .bp_fire(bp_fire), .wp_addr(wp_addr),
    .can_take(hit_rdy), .out_ready(exc_ready),
    .out_valid(exc_valid), .out_kind(exc_kind),
    .out_addr(exc_addr), .out_info(exc_info)
  );

  p_feat_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rdy && !feat_en |=> !exc_valid);

  p_sel_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rdy && !wp_hit && bp_priv == 2'd0 |=> !exc_valid);

  p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !hit_rdy);
endmodule

// File: tb/test_dbg_hit_qualifier.sv
module test_dbg_hit_qualifier;
  localparam int AW = 64;
  localparam time CLK_PERIOD = 10ns;

  localparam logic [63:0] DSI_EXP   = 64'h0000_0000_0040_0000;
  localparam logic [63:0] TRACE_EXP = 64'h0000_0000_4010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic feat_en = 1'b1, msr_pr = 1'b0, msr_hv = 1'b0, msr_dr = 1'b0;
  logic bp_hit = 1'b0, wp_hit = 1'b0, exc_ready = 1'b1;
  logic [1:0] bp_priv = 2'd0;
  logic [AW-1:0] wp_addr = '0;
  logic [4:0] wp_ctl = '0;
  logic hit_rdy, exc_valid;
  logic [1:0] exc_kind;
  logic [AW-1:0] exc_addr;
  logic [63:0] exc_info;

  typedef struct packed {
    logic [1:0]    k;
    logic [AW-1:0] a;
    logic [63:0]   i;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_hit_qualifier #(.AW(AW)) i_dbg_hit_qualifier (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en),
    .msr_pr(msr_pr), .msr_hv(msr_hv), .msr_dr(msr_dr),
    .bp_hit(bp_hit), .bp_priv(bp_priv),
    .wp_hit(wp_hit), .wp_addr(wp_addr), .wp_ctl(wp_ctl),
    .hit_rdy(hit_rdy), .exc_valid(exc_valid), .exc_ready(exc_ready),
    .exc_kind(exc_kind), .exc_addr(exc_addr), .exc_info(exc_info)
  );

  function automatic logic bp_model(logic [1:0] s, logic pr, logic hv);
    return (s == 2'd1 && pr) || (s == 2'd2 && !pr && !hv) || (s == 2'd3 && !pr && hv);
  endfunction

  function automatic logic wp_model(logic [4:0] c, logic pr, logic hv, logic dr);
    if (pr && !c[0]) return 1'b0;
    if (hv && !c[2]) return 1'b0;
    if (!c[1]) return 1'b0;
    if (!c[3] && (c[4] != dr)) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compare on every completed handshake
  always @(negedge clk) begin
    if (rst_n && exc_valid && exc_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2/R4/R8: actual unexpected kind %0d expected no request", exc_kind);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({exc_kind, exc_addr, exc_info} !== e) begin
          n_bad++;
          $display("FAIL %s: actual kind %0d addr %0h info %0h expected kind %0d addr %0h info %0h",
                   t, exc_kind, exc_addr, exc_info, e.k, e.a, e.i);
        end
      end
    end
  end

  task automatic run(logic bp, logic [1:0] s, logic wp, logic [AW-1:0] a, logic [4:0] c,
                     logic pr, logic hv, logic dr, logic fe, string req);
    logic bq, wq;
    @(negedge clk);
    while (!hit_rdy) @(negedge clk);
    bp_hit = bp; bp_priv = s; wp_hit = wp; wp_addr = a; wp_ctl = c;
    msr_pr = pr; msr_hv = hv; msr_dr = dr; feat_en = fe;
    bq = fe && bp && bp_model(s, pr, hv);
    wq = fe && wp && wp_model(c, pr, hv, dr);
    if (wq) begin exp_q.push_back({2'd1, a, DSI_EXP}); tag_q.push_back({req, " R6"}); end
    if (bq) begin exp_q.push_back({2'd2, {AW{1'b0}}, TRACE_EXP}); tag_q.push_back({req, " R7"}); end
    @(negedge clk);
    bp_hit = 1'b0; wp_hit = 1'b0;
    check({req, " R11"}, {127'b0, exc_valid}, {127'b0, (bq || wq)});
    repeat (4) @(negedge clk);
    check({req, " drained"}, {96'b0, 32'(exp_q.size())}, 128'b0);
    exp_q.delete(); tag_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", {127'b0, exc_valid}, 128'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdy", {127'b0, hit_rdy}, 128'b1);

    // R2 / R3: breakpoint selector sweep over every state
    for (int s = 0; s < 4; s++)
      for (int st = 0; st < 8; st++)
        run(1'b1, 2'(s), 1'b0, '0, 5'd0, st[0], st[1], st[2], 1'b1,
            (s == 0) ? "R3 sel0" : "R2 sel");

    // R4 / R5: watchpoint control sweep over every state
    for (int c = 0; c < 32; c++)
      for (int st = 0; st < 8; st++)
        run(1'b0, 2'd0, 1'b1, 64'hDEAD_0000_0000_0000 | 64'(c * 8 + st), 5'(c),
            st[0], st[1], st[2], 1'b1, "R4 R5 wp");

    // R8: feature disabled, both strobes otherwise qualifying
    run(1'b1, 2'd1, 1'b1, 64'h1000, 5'b01111, 1'b1, 1'b0, 1'b0, 1'b0, "R8 off");
    run(1'b1, 2'd3, 1'b1, 64'h2000, 5'b11111, 1'b0, 1'b1, 1'b1, 1'b0, "R8 off hv");

    // R9: both in one cycle, watchpoint first then breakpoint
    run(1'b1, 2'd2, 1'b1, 64'hCAFE_F00D, 5'b01110, 1'b0, 1'b0, 1'b0, 1'b1, "R9 both");
    run(1'b1, 2'd1, 1'b1, 64'h8000_0000_0000_0008, 5'b10001 | 5'b00010, 1'b1, 1'b0, 1'b1, 1'b1, "R9 both pr");

    // R10: hold under back-pressure, strobes ignored while held
    @(negedge clk);
    exc_ready = 1'b0;
    wp_hit = 1'b1; wp_addr = 64'h55AA; wp_ctl = 5'b01111; msr_pr = 1'b0; msr_hv = 1'b0; feat_en = 1'b1;
    exp_q.push_back({2'd1, 64'h55AA, DSI_EXP}); tag_q.push_back("R10 held");
    @(negedge clk);
    wp_hit = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R10 valid held", {127'b0, exc_valid}, 128'b1);
      check("R10 rdy low", {127'b0, hit_rdy}, 128'b0);
      check("R10 stable", {62'b0, exc_kind, exc_addr}, {62'b0, 2'd1, 64'h55AA});
      bp_hit = (k == 1); bp_priv = 2'd2;
      @(negedge clk);
    end
    bp_hit = 1'b0;
    @(posedge clk);
    #1 exc_ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 ignored strobe", {96'b0, 32'(exp_q.size())}, 128'b0);
    check("R10 idle", {127'b0, exc_valid}, 128'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule